// File: doc/BRIEF.md
# Packed Rounding Shift Unit

This block is a purely combinational datapath that shifts packed data, with optional rounding. It has four operations. The first shifts four signed byte lanes right arithmetically. The second shifts two unsigned halfword lanes right logically. The third narrows two signed 32-bit words into one packed word of two halfwords. The fourth is a Q31 fractional multiply that can round and that clips its one overflow case.

The result is a pure function of the present inputs. There is no register and no handshake. It suits a single-cycle execute stage that registers the result downstream. The valid/ready rules of a stream interface do not apply: an operation is complete whenever its inputs are stable, and the consumer cannot hold off the unit.

Top module: `packed_shift_unit`

## Requirements
- R1: The operation select `op_sel` has these encodings: 0 selects the signed byte shift, 1 the unsigned halfword shift, 2 the narrowing pack, and 3 the Q31 multiply.
- R2: In the byte shift, each 8-bit lane of `opnd_a` (lane k is bits 8k+7:8k) is shifted right arithmetically by `shamt[2:0]`. Each lane is independent of the others, and the result is kept to 8 bits.
- R3: When `rnd_en` is 1 and the shift amount s is nonzero, a lane whose input bit s-1 is set gets 1 added after the arithmetic shift, for the byte shift and the narrowing pack. The sum wraps to the lane width.
- R4: When the shift amount is zero, the byte shift returns `opnd_a` unchanged and the narrowing pack returns `{opnd_a[15:0], opnd_b[15:0]}`, whatever the value of `rnd_en`.
- R5: In the halfword shift, each 16-bit lane of `opnd_a` is shifted right logically by `shamt[3:0]`, with zeros filling from the top. `rnd_en` has no effect on this operation.
- R6: The narrowing pack shifts `opnd_a` and `opnd_b` right arithmetically by the same `shamt[4:0]`. Bits 15:0 of the shifted `opnd_a` go to result bits 31:16, and bits 15:0 of the shifted `opnd_b` go to result bits 15:0.
- R7: The Q31 multiply forms the 64-bit signed product of `opnd_a` and `opnd_b` and doubles it. When `rnd_en` is 1 it adds 0x80000000. The result is bits 63:32 of that sum.
- R8: When both multiply operands are 0x80000000, the result is 0x7FFFFFFF and `ovf` is 1. In every other case, including every other operation, `ovf` is 0.
- R9: Without rounding, a multiply of two nonzero operands that does not overflow gives a result whose sign bit is the XOR of the operand sign bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand: the packed lanes, the upper word of the pack, or the multiplicand |
| opnd_b | input | 32 | Second operand: the lower word of the pack, or the multiplier |
| shamt | input | 5 | Shift amount; the byte shift uses bits 2:0 and the halfword shift uses bits 3:0 |
| op_sel | input | 2 | Operation select (see R1) |
| rnd_en | input | 1 | Rounding enable |
| result | output | 32 | Packed result |
| ovf | output | 1 | Multiply overflow indication |

## Verification
The assertions check four properties on every change of the inputs:
- the overflow flag fires only for the single overflowing multiply operand pair, and always returns 0x7FFFFFFF;
- a zero shift passes the data through;
- a logical halfword shift never increases a lane;
- an unrounded product keeps the XOR of the operand signs.

Some behaviour only the bench scenarios can show. This covers the exact rounding increments per lane, the lane isolation under random operands, the placement of the two halves in the pack, and the bit-exact rounded multiply. The bench compares each of these against its own reference functions across every shift amount.

// File: rtl/pshift_pkg.sv
package pshift_pkg;
  typedef enum logic [1:0] {
    OP_BYTE_SRA = 2'd0,
    OP_HALF_SRL = 2'd1,
    OP_PACK_SRA = 2'd2,
    OP_Q31_MUL  = 2'd3
  } pshift_op_e;
  localparam logic [31:0] Q31_MIN = 32'h8000_0000;
  localparam logic [31:0] Q31_MAX = 32'h7FFF_FFFF;
endpackage

// File: rtl/rnd_sra_lane.sv
// Arithmetic right shift of one lane, with an optional round-half-up
// that adds back the last bit shifted out.
module rnd_sra_lane #(
  parameter int W  = 8,
  parameter int SW = 3
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] sh,
  input  logic          rnd,
  output logic [W-1:0]  dout
);
  logic [W-1:0]  shifted;
  logic [SW-1:0] sh_m1;
  logic          rbit;

  always_comb begin
    shifted = $signed(din) >>> sh;
    sh_m1   = sh - 1'b1;
    rbit    = rnd && (sh != '0) && din[sh_m1];
    dout    = shifted + {{(W-1){1'b0}}, rbit};
  end
endmodule

// File: rtl/q31_mul.sv
// Doubled signed product, returning the high word; the single
// unrepresentable case is clipped to the largest positive value.
module q31_mul #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         rnd,
  output logic [W-1:0] p,
  output logic         clip
);
  localparam int PW = 2 * W;
  logic signed [PW-1:0] ax, bx, prod, dbl;
  logic [W-1:0] minv;

  always_comb begin
    minv = {1'b1, {(W-1){1'b0}}};
    ax   = $signed({{W{a[W-1]}}, a});
    bx   = $signed({{W{b[W-1]}}, b});
    prod = ax * bx;
    dbl  = prod <<< 1;
    if (rnd) dbl = dbl + $signed({{(W+1){1'b0}}, {(W-1){1'b1}}} + 1'b1);
    clip = (a == minv) && (b == minv);
    p    = clip ? ~minv : dbl[PW-1:W];
  end
endmodule

// File: rtl/packed_shift_unit.sv
module packed_shift_unit
  import pshift_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [31:0] opnd_a,
  input  logic [31:0] opnd_b,
  input  logic [4:0]  shamt,
  input  logic [1:0]  op_sel,
  input  logic        rnd_en,
  output logic [31:0] result,
  output logic        ovf
);
  localparam int BW     = 8;
  localparam int HW     = DW / 2;
  localparam int NBYTE  = DW / BW;
  localparam int NHALF  = DW / HW;
  localparam int BSW    = $clog2(BW);
  localparam int HSW    = $clog2(HW);
  localparam int WSW    = $clog2(DW);

  logic [DW-1:0] byte_res, half_res, pack_res, mul_res;
  logic [HW-1:0] pack_hi_w [2];
  logic [DW-1:0] pack_full [2];
  logic          mul_clip;

  // Signed byte lanes with rounding
  for (genvar k = 0; k < NBYTE; k++) begin : g_byte
    rnd_sra_lane #(.W(BW), .SW(BSW)) u_lane (
      .din  (opnd_a[k*BW +: BW]),
      .sh   (shamt[BSW-1:0]),
      .rnd  (rnd_en),
      .dout (byte_res[k*BW +: BW])
    );
  end

  // Unsigned halfword lanes, logical, never rounded
  for (genvar k = 0; k < NHALF; k++) begin : g_half
    assign half_res[k*HW +: HW] = opnd_a[k*HW +: HW] >> shamt[HSW-1:0];
  end

  // Narrowing pack: word 0 is opnd_a (upper half), word 1 is opnd_b
  for (genvar k = 0; k < 2; k++) begin : g_pack
    rnd_sra_lane #(.W(DW), .SW(WSW)) u_word (
      .din  (k == 0 ? opnd_a : opnd_b),
      .sh   (shamt[WSW-1:0]),
      .rnd  (rnd_en),
      .dout (pack_full[k])
    );
    assign pack_hi_w[k] = pack_full[k][HW-1:0];
  end
  assign pack_res = {pack_hi_w[0], pack_hi_w[1]};

  q31_mul #(.W(DW)) u_mul (
    .a    (opnd_a),
    .b    (opnd_b),
    .rnd  (rnd_en),
    .p    (mul_res),
    .clip (mul_clip)
  );

  always_comb begin
    unique case (pshift_op_e'(op_sel))
      OP_BYTE_SRA: result = byte_res;
      OP_HALF_SRL: result = half_res;
      OP_PACK_SRA: result = pack_res;
      default:     result = mul_res;
    endcase
    ovf = (pshift_op_e'(op_sel) == OP_Q31_MUL) && mul_clip;
  end
endmodule

// File: rtl/packed_shift_unit_chk.sv
module packed_shift_unit_chk
  import pshift_pkg::*;
(
  input logic [31:0] opnd_a,
  input logic [31:0] opnd_b,
  input logic [4:0]  shamt,
  input logic [1:0]  op_sel,
  input logic        rnd_en,
  input logic [31:0] result,
  input logic        ovf
);
  always_comb begin
    // R8
    ovf_only_min_pair_chk: assert (!ovf || (op_sel == 2'd3 && opnd_a == Q31_MIN
                                   && opnd_b == Q31_MIN && result == Q31_MAX));
    // R4
    zero_shift_pass_chk: assert (!((op_sel == 2'd0 && shamt[2:0] == 3'd0 && result != opnd_a) ||
                                   (op_sel == 2'd2 && shamt == 5'd0 &&
                                    result != {opnd_a[15:0], opnd_b[15:0]})));
    // R5
    half_not_grow_chk: assert (op_sel != 2'd1 ||
                               (result[31:16] <= opnd_a[31:16] && result[15:0] <= opnd_a[15:0]));
    // R9
    mul_sign_chk: assert (!(op_sel == 2'd3 && !rnd_en && opnd_a != 0 && opnd_b != 0 && !ovf)
                          || result[31] == (opnd_a[31] ^ opnd_b[31]));
  end
endmodule

bind packed_shift_unit packed_shift_unit_chk i_chk (
  .opnd_a (opnd_a),
  .opnd_b (opnd_b),
  .shamt  (shamt),
  .op_sel (op_sel),
  .rnd_en (rnd_en),
  .result (result),
  .ovf    (ovf)
);

// File: tb/test_packed_shift_unit.sv
`timescale 1ns/1ps
module test_packed_shift_unit;
  logic        clk = 1'b0;
  logic [31:0] opnd_a, opnd_b, result;
  logic [4:0]  shamt;
  logic [1:0]  op_sel;
  logic        rnd_en, ovf;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  packed_shift_unit i_packed_shift_unit (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .shamt(shamt), .op_sel(op_sel),
    .rnd_en(rnd_en), .result(result), .ovf(ovf)
  );

  function automatic logic [31:0] lane_sra(logic [31:0] v, int w, int s, bit r);
    longint x, y;
    x = (w == 8) ? longint'($signed(v[7:0])) : longint'($signed(v));
    y = x >>> s;
    if (r && s != 0 && x[s-1]) y = y + 1;
    return y[31:0];
  endfunction

  function automatic logic [31:0] ref_model(logic [1:0] op, logic [31:0] a, logic [31:0] b,
                                            logic [4:0] s, bit r, output bit o);
    logic [31:0] res;
    longint p;
    o = 1'b0;
    res = '0;
    case (op)
      2'd0: for (int k = 0; k < 4; k++) res[8*k +: 8] = lane_sra({24'd0, a[8*k +: 8]}, 8, int'(s[2:0]), r) & 32'hFF;
      2'd1: for (int k = 0; k < 2; k++) res[16*k +: 16] = a[16*k +: 16] >> s[3:0];
      2'd2: res = {lane_sra(a, 32, int'(s), r) & 32'h0000FFFF, 16'h0} | (lane_sra(b, 32, int'(s), r) & 32'h0000FFFF);
      default: begin
        if (a == 32'h8000_0000 && b == 32'h8000_0000) begin
          o = 1'b1; res = 32'h7FFF_FFFF;
        end else begin
          p = longint'($signed(a)) * longint'($signed(b));
          p = p << 1;
          if (r) p = p + 64'h8000_0000;
          res = p[63:32];
        end
      end
    endcase
    return res;
  endfunction

  task automatic check(string req, logic [1:0] op, logic [31:0] a, logic [31:0] b,
                       logic [4:0] s, bit r);
    logic [31:0] exp;
    bit eo;
    @(negedge clk);
    op_sel = op; opnd_a = a; opnd_b = b; shamt = s; rnd_en = r;
    #1;
    exp = ref_model(op, a, b, s, r, eo);
    n_chk++;
    if (result !== exp || ovf !== eo) begin
      n_fail++;
      $display("FAIL %s: op=%0d a=%h b=%h s=%0d r=%0b result=%h ovf=%b expected %h ovf=%b",
               req, op, a, b, s, r, result, ovf, exp, eo);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    op_sel = 0; opnd_a = 0; opnd_b = 0; shamt = 0; rnd_en = 0;
    check("R1 idle zero", 2'd0, 32'h0, 32'h0, 5'd0, 1'b0);
    // R4: zero shift passes through even with rounding on
    check("R4", 2'd0, 32'h7F80_FF01, 32'h0, 5'd0, 1'b1);
    check("R4", 2'd2, 32'h1234_ABCD, 32'h8765_4321, 5'd0, 1'b1);
    // R2/R3: per-lane rounding increments
    check("R3", 2'd0, 32'hFF80_7F01, 32'h0, 5'd1, 1'b1);
    check("R2", 2'd0, 32'h8080_8080, 32'h0, 5'd7, 1'b0);
    check("R3", 2'd0, 32'h80C0_4040, 32'h0, 5'd7, 1'b1);
    // R5: logical halfword, rounding ignored
    check("R5", 2'd1, 32'hFFFF_8001, 32'h0, 5'd15, 1'b1);
    check("R5", 2'd1, 32'h8000_0003, 32'h0, 5'd1, 1'b1);
    // R6: pack placement and sign
    check("R6", 2'd2, 32'h8000_0000, 32'h0001_0000, 5'd16, 1'b0);
    check("R3", 2'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd31, 1'b1);
    // R7/R8/R9: multiply
    check("R8", 2'd3, 32'h8000_0000, 32'h8000_0000, 5'd0, 1'b1);
    check("R8", 2'd3, 32'h8000_0000, 32'h8000_0000, 5'd0, 1'b0);
    check("R8", 2'd2, 32'h8000_0000, 32'h8000_0000, 5'd0, 1'b0);
    check("R7", 2'd3, 32'h4000_0000, 32'h4000_0000, 5'd0, 1'b0);
    check("R7", 2'd3, 32'h0000_0001, 32'h4000_0000, 5'd0, 1'b1);
    check("R9", 2'd3, 32'hFFFF_FFFF, 32'h0000_0001, 5'd0, 1'b0);
    check("R9", 2'd3, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0, 1'b0);
    // Sweep every shift amount on every operation with random operands
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      logic [1:0]  op;
      a  = $urandom();
      b  = $urandom();
      op = 2'(i % 4);
      if (op == 2'd3 && ($urandom() % 16) == 0) begin a = 32'h8000_0000; b = 32'h8000_0000; end
      check(op == 2'd0 ? "R2" : op == 2'd1 ? "R5" : op == 2'd2 ? "R6" : "R7",
            op, a, b, 5'((i / 4) % 32), 1'($urandom()));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule